// File: doc/BRIEF.md
# Power-Up Reset, Clock and Isolation Sequencer

This block brings one or more voltage domains out of power-up in a fixed order. It samples a power-good bit for each domain and a PLL lock flag, and it qualifies them by cycle counting before it trusts them. Once every domain has held good long enough, it runs a dummy request/acknowledge round trip through its own synchronizers to clear any stale state. It then enables the core clock, then releases reset, then removes isolation. Each release waits for its own delay, measured in clock cycles from the moment power-good was qualified.

A loss of any power-good bit, or a loss of PLL lock once the clock is running, drives all three controls back to their safe values on the next edge and starts the sequence from the beginning. A step output shows where the sequence stands. A done flag marks the point where isolation has been removed.

Top module: `pwr_seq_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `core_clk_en` is 0, `core_rst` is 1, `iso_en` is 1, `seq_done` is 0 and `seq_step` is 0.
- R2: The `pg_raw` and `pll_lock_raw` inputs pass through SYNC_STAGES flip-flops before any logic uses them. A change on a raw input cannot affect any output before SYNC_STAGES+1 rising edges have passed.
- R3: The sequence leaves step 0 only after every bit of the synchronized power-good has been high together for DG_CYC consecutive edges. A single low cycle on any bit restarts that count.
- R4: After qualification the sequencer spends step 1 on a dummy toggle handshake through two synchronizer chains. The handshake lasts 2*SYNC_STAGES+1 cycles before step 2.
- R5: `core_clk_en` rises only when the synchronized lock is high and at least CLK_DLY cycles have passed since qualification (step 3).
- R6: `core_rst` falls only while `core_clk_en` is high and at least HOLD_CYC cycles have passed since qualification (step 4).
- R7: `iso_en` falls only after reset has been released and at least ISO_NOM + ISO_NOM/10 cycles have passed since qualification. `seq_done` is high exactly in that final state (step 5).
- R8: When any synchronized power-good bit is low at an edge, that edge sets clock off, reset on, isolation on and step 0. The sequence then restarts by itself.
- R9: Lock low while the clock is still off only holds the sequence in step 2. Lock lost at step 3 or later returns everything to the safe state and to step 0.
- R10: `seq_step` encodes 0 idle/qualifying, 1 flush, 2 waiting for clock, 3 clock on, 4 reset released, 5 done. It never shows any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_raw | input | N_DOM | Raw power-good, one bit per domain, may bounce |
| pll_lock_raw | input | 1 | Raw PLL lock flag |
| core_clk_en | output | 1 | Clock enable to the core, 1 = running |
| core_rst | output | 1 | Core reset, 1 = held in reset |
| iso_en | output | 1 | Isolation clamp, 1 = isolated |
| seq_done | output | 1 | High once isolation is released |
| seq_step | output | 3 | Current sequence step |

## Verification
The collision that matters is a fault arriving in the same cycle as a forward step. A power-good drop or a lock loss can land at the edge where a delay threshold would otherwise advance the sequence, so abort and advance compete for the same state register. The bench provokes this by dropping a power-good bit while the clock is already running and by cutting lock right after done. It also places a one-cycle power-good glitch inside the qualification window. A cycle-accurate behavioural model judges every edge, expecting the abort to win and all outputs to return to the safe values together.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_FLUSH    = 3'd1,
    ST_WAIT_CLK = 3'd2,
    ST_CLK_ON   = 3'd3,
    ST_RST_OFF  = 3'd4,
    ST_DONE     = 3'd5
  } seq_st_e;
endpackage

// File: rtl/pwr_seq_sync.sv
// Multi-bit flop chain for asynchronous level inputs (each bit independent).
module pwr_seq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwr_seq_qual.sv
// Counts consecutive cycles with all rails good; saturates at RUN_MAX.
module pwr_seq_qual #(
  parameter int DG_CYC  = 16,
  parameter int RUN_MAX = 64,
  parameter int CW      = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          all_good,
  output logic [CW-1:0] run,
  output logic          pg_ok
);
  always_ff @(posedge clk) begin
    if (rst || !all_good)         run <= '0;
    else if (run != CW'(RUN_MAX)) run <= run + 1'b1;
  end

  assign pg_ok = (run >= CW'(DG_CYC));
endmodule

// File: rtl/pwr_seq_flush.sv
// Dummy toggle handshake: request out through one chain, echo back through another.
module pwr_seq_flush #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  logic req_q;
  logic req_far;
  logic ack_near;

  always_ff @(posedge clk) begin
    if (rst)        req_q <= 1'b0;
    else if (start) req_q <= ~req_q;
  end

  pwr_seq_sync #(.W(1), .STAGES(STAGES)) u_fwd (
    .clk(clk), .rst(rst), .d(req_q), .q(req_far)
  );

  pwr_seq_sync #(.W(1), .STAGES(STAGES)) u_back (
    .clk(clk), .rst(rst), .d(req_far), .q(ack_near)
  );

  assign done = (ack_near == req_q);
endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
  import pwr_seq_pkg::*;
#(
  parameter int N_DOM       = 2,
  parameter int SYNC_STAGES = 3,
  parameter int DG_CYC      = 16,
  parameter int CLK_DLY     = 125,
  parameter int HOLD_CYC    = 2500,
  parameter int ISO_NOM     = 3000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DOM-1:0] pg_raw,
  input  logic             pll_lock_raw,
  output logic             core_clk_en,
  output logic             core_rst,
  output logic             iso_en,
  output logic             seq_done,
  output logic [2:0]       seq_step
);
  localparam int ISO_CYC = ISO_NOM + ISO_NOM / 10;
  localparam int RUN_MAX = DG_CYC + ISO_CYC;
  localparam int CW      = $clog2(RUN_MAX + 1);

  logic [N_DOM:0]   raw_bus;
  logic [N_DOM:0]   syn_bus;
  logic [N_DOM-1:0] pg_s;
  logic             lock_s;
  logic             pg_all;
  logic [CW-1:0]    run;
  logic             pg_ok;
  logic             flush_start;
  logic             flush_done;
  logic             abort;
  seq_st_e          state, nstate;

  assign raw_bus = {pll_lock_raw, pg_raw};

  pwr_seq_sync #(.W(N_DOM + 1), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(syn_bus)
  );

  assign pg_s   = syn_bus[N_DOM-1:0];
  assign lock_s = syn_bus[N_DOM];
  assign pg_all = &pg_s;

  pwr_seq_qual #(.DG_CYC(DG_CYC), .RUN_MAX(RUN_MAX), .CW(CW)) u_qual (
    .clk(clk), .rst(rst), .all_good(pg_all), .run(run), .pg_ok(pg_ok)
  );

  pwr_seq_flush #(.STAGES(SYNC_STAGES)) u_flush (
    .clk(clk), .rst(rst), .start(flush_start), .done(flush_done)
  );

  // Fault: any rail low, or lock lost once the clock is released.
  assign abort = !pg_all ||
                 (!lock_s && (state inside {ST_CLK_ON, ST_RST_OFF, ST_DONE}));

  assign flush_start = (state == ST_IDLE) && !abort && pg_ok;

  always_comb begin
    nstate = state;
    if (abort) begin
      nstate = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:     if (pg_ok) nstate = ST_FLUSH;
        ST_FLUSH:    if (flush_done) nstate = ST_WAIT_CLK;
        ST_WAIT_CLK: if (lock_s && run >= CW'(DG_CYC + CLK_DLY)) nstate = ST_CLK_ON;
        ST_CLK_ON:   if (run >= CW'(DG_CYC + HOLD_CYC)) nstate = ST_RST_OFF;
        ST_RST_OFF:  if (run >= CW'(DG_CYC + ISO_CYC)) nstate = ST_DONE;
        ST_DONE:     nstate = ST_DONE;
        default:     nstate = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      core_clk_en <= 1'b0;
      core_rst    <= 1'b1;
      iso_en      <= 1'b1;
      seq_done    <= 1'b0;
      seq_step    <= 3'd0;
    end else begin
      state       <= nstate;
      core_clk_en <= (nstate inside {ST_CLK_ON, ST_RST_OFF, ST_DONE});
      core_rst    <= !(nstate inside {ST_RST_OFF, ST_DONE});
      iso_en      <= (nstate != ST_DONE);
      seq_done    <= (nstate == ST_DONE);
      seq_step    <= nstate;
    end
  end
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int CW       = 8,
  parameter int DG_CYC   = 16,
  parameter int CLK_DLY  = 125,
  parameter int HOLD_CYC = 2500,
  parameter int ISO_CYC  = 3300
) (
  input logic          clk,
  input logic          rst,
  input logic          pg_all,
  input logic          lock_s,
  input logic [CW-1:0] run,
  input logic          core_clk_en,
  input logic          core_rst,
  input logic          iso_en,
  input logic          seq_done,
  input logic [2:0]    seq_step
);
  p_clk_gate_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(core_clk_en) |-> ($past(lock_s) && $past(run) >= CW'(DG_CYC + CLK_DLY)));

  p_clk_before_rst_r6: assert property (@(posedge clk) disable iff (rst)
    !core_rst |-> core_clk_en);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst) |-> ($past(run) >= CW'(DG_CYC + HOLD_CYC)));

  p_rst_before_iso_r7: assert property (@(posedge clk) disable iff (rst)
    !iso_en |-> !core_rst);

  p_iso_margin_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(iso_en) |-> ($past(run) >= CW'(DG_CYC + ISO_CYC)));

  p_done_r7: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> !iso_en);

  p_safe_on_drop_r8: assert property (@(posedge clk) disable iff (rst)
    !pg_all |=> (core_rst && !core_clk_en && iso_en && seq_step == 3'd0));

  p_lock_loss_r9: assert property (@(posedge clk) disable iff (rst)
    (core_clk_en && !lock_s) |=> (!core_clk_en && core_rst && iso_en));

  p_step_legal_r10: assert property (@(posedge clk) disable iff (rst)
    seq_step <= 3'd5);
endmodule

bind pwr_seq_top pwr_seq_chk #(
  .CW(CW), .DG_CYC(DG_CYC), .CLK_DLY(CLK_DLY), .HOLD_CYC(HOLD_CYC), .ISO_CYC(ISO_CYC)
) u_chk (
  .clk(clk), .rst(rst), .pg_all(pg_all), .lock_s(lock_s), .run(run),
  .core_clk_en(core_clk_en), .core_rst(core_rst), .iso_en(iso_en),
  .seq_done(seq_done), .seq_step(seq_step)
);

// File: tb/tb_pwr_seq_top.sv
`timescale 1ns/1ps
module tb_pwr_seq_top;
  localparam int ND  = 2;
  localparam int SS  = 3;
  localparam int DG  = 16;
  localparam int CD  = 20;
  localparam int HD  = 40;
  localparam int IN  = 50;
  localparam int ISO = IN + IN / 10;
  localparam int MAXR = DG + ISO;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst;
  logic [ND-1:0] pg;
  logic          lock;
  logic          core_clk_en, core_rst, iso_en, seq_done;
  logic [2:0]    seq_step;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;
  bit cmp_on = 0;

  pwr_seq_top #(
    .N_DOM(ND), .SYNC_STAGES(SS), .DG_CYC(DG), .CLK_DLY(CD), .HOLD_CYC(HD), .ISO_NOM(IN)
  ) dut (
    .clk(clk), .rst(rst), .pg_raw(pg), .pll_lock_raw(lock),
    .core_clk_en(core_clk_en), .core_rst(core_rst), .iso_en(iso_en),
    .seq_done(seq_done), .seq_step(seq_step)
  );

  // Behavioural reference model
  int m_st, m_run, m_fc;
  logic [ND:0] hist[$];

  always @(posedge clk) begin
    logic [ND:0] old;
    bit pga, lk, abrt;
    int nst;
    if (rst) begin
      m_st = 0; m_run = 0; m_fc = 0;
      hist.delete();
      for (int i = 0; i < SS; i++) hist.push_back('0);
    end else begin
      old  = hist[0];
      pga  = &old[ND-1:0];
      lk   = old[ND];
      abrt = !pga || (m_st >= 3 && !lk);
      nst  = m_st;
      if (abrt) nst = 0;
      else begin
        case (m_st)
          0: if (m_run >= DG) begin nst = 1; m_fc = 0; end
          1: if (m_fc == 2 * SS) nst = 2; else m_fc++;
          2: if (lk && m_run - DG >= CD) nst = 3;
          3: if (m_run - DG >= HD) nst = 4;
          4: if (m_run - DG >= ISO) nst = 5;
          default: nst = m_st;
        endcase
      end
      m_st = nst;
      if (!pga) m_run = 0;
      else if (m_run < MAXR) m_run++;
      void'(hist.pop_front());
      hist.push_back({lock, pg});
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R5 core_clk_en vs model", int'(core_clk_en), int'(m_st >= 3));
      chk("R6 core_rst vs model",    int'(core_rst),    int'(m_st < 4));
      chk("R7 iso_en vs model",      int'(iso_en),      int'(m_st != 5));
      chk("R7 seq_done vs model",    int'(seq_done),    int'(m_st == 5));
      chk("R10 seq_step vs model",   int'(seq_step),    m_st);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; pg = '0; lock = 1'b0;
    cyc(5);
    chk("R1 clk_en in reset", int'(core_clk_en), 0);
    chk("R1 core_rst in reset", int'(core_rst), 1);
    chk("R1 iso_en in reset", int'(iso_en), 1);
    chk("R1 done in reset", int'(seq_done), 0);
    rst = 1'b0;
    cmp_on = 1;
    cyc(1);
    chk("R1 step after reset", int'(seq_step), 0);

    // Scenario A: clean power-up, lock already present
    lock = 1'b1; pg = '1;
    cyc(DG + SS);
    chk("R2/R3 step before qualification", int'(seq_step), 0);
    cyc(1);
    chk("R3 step after qualification", int'(seq_step), 1);
    cyc(2 * SS);
    chk("R4 still flushing", int'(seq_step), 1);
    cyc(1);
    chk("R4 flush complete", int'(seq_step), 2);
    cyc(80);
    chk("R7 done after full sequence", int'(seq_done), 1);

    // Scenario B: one-cycle drop on one rail while done
    pg[1] = 1'b0; cyc(1); pg[1] = 1'b1;
    cyc(SS);
    chk("R8 clock off after drop", int'(core_clk_en), 0);
    chk("R8 reset on after drop", int'(core_rst), 1);
    chk("R8 isolation on after drop", int'(iso_en), 1);
    chk("R8 step zero after drop", int'(seq_step), 0);
    cyc(120);
    chk("R8 restart reaches done", int'(seq_done), 1);

    // Scenario C: glitch inside the qualification window
    pg = '0; cyc(10);
    pg = '1; cyc(10);
    pg[0] = 1'b0; cyc(1); pg[0] = 1'b1;
    cyc(DG + SS - 11);
    chk("R3 glitch restarts count", int'(seq_step), 0);
    cyc(120);

    // Scenario D: lock missing before clock release, then lost after done
    pg = '0; lock = 1'b0; cyc(10);
    pg = '1; cyc(100);
    chk("R9 stalled at step 2", int'(seq_step), 2);
    chk("R9 clock held off", int'(core_clk_en), 0);
    lock = 1'b1; cyc(10);
    chk("R9 done after lock arrives", int'(seq_done), 1);
    lock = 1'b0; cyc(SS + 1);
    chk("R9 lock loss clock off", int'(core_clk_en), 0);
    chk("R9 lock loss step zero", int'(seq_step), 0);
    lock = 1'b1; cyc(120);

    // Scenario E: rail drop while clock running but reset still held
    pg = '0; cyc(10);
    pg = '1; cyc(DG + SS + 2 * SS + 1 + CD + 3);
    chk("R5 clock on mid-sequence", int'(core_clk_en), 1);
    chk("R6 reset still held", int'(core_rst), 1);
    pg[0] = 1'b0; cyc(SS + 1);
    chk("R8 drop mid-sequence safe", int'(core_clk_en), 0);
    pg[0] = 1'b1; cyc(120);
    chk("R7 final done", int'(seq_done), 1);

    cmp_on = 0;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule